// File: doc/BRIEF.md
# Sharer chain manager

This block keeps, for each memory block homed at one node, the set of caches holding a copy as a doubly linked chain spread across the caches. The home remembers only which cache is first in the chain. Each cache copy remembers the cache after it (forward pointer) and the cache before it (backward pointer). The pointer storage for both the home heads and the per-cache tags is held in register arrays inside the block. A peek port lets a neighbouring controller read any head or tag without side effects.

A read request links the requesting node in at the front of the chain. A write request walks the chain from the front. It sends an invalidation to each sharer in turn and waits for that sharer's acknowledge before it reads the next pointer. The walk cannot look ahead, because the next sharer is only known once the current one has been visited, so write latency grows with the chain length. When the walk reaches the null pointer, the writer becomes the only member of the chain. An eviction request unlinks one node by joining its neighbours. One request is handled at a time, and each request ends with a one-cycle done pulse.

The controller has eight states:

| State | Role | Leaves for |
|---|---|---|
| IDLE | ready for a request | LINK on a read, SCAN_START on a write, UNLINK on an evict, DONE on a no-op |
| LINK | inserts at the front | DONE |
| UNLINK | removes a node | DONE |
| SCAN_START | loads the head into the walk cursor | SCAN |
| SCAN | on a null cursor, finishes the walk; on the writer, advances the cursor without a message; otherwise sends an invalidation | CLAIM, SCAN or INVAL |
| INVAL | holds the invalidation until it is acknowledged, then drops that sharer and advances | SCAN |
| CLAIM | makes the writer the sole sharer | DONE |
| DONE | pulses done | IDLE |

Top module: `sharer_chain_mgr`

## Requirements
- R1: The null pointer is the value NODES (8 by default). After reset every home head is null, no node is present for any block, req_ready is 1, and done and inv_valid are 0.
- R2: A read (req_op 0) by a node not yet in the chain makes it the head. Its forward pointer becomes the old head and its backward pointer becomes null. When the old head is not null, the old head's backward pointer becomes the new node.
- R3: A read by a node already in the chain leaves every head, pointer and presence bit of that block unchanged.
- R4: A write (req_op 1) sends invalidations one at a time in chain order, from the head toward the tail. inv_valid stays high with a stable inv_node until inv_ack is seen, and the next invalidation starts only after that acknowledge.
- R5: The writer never receives an invalidation, even when it is already in the chain. The walk steps past the writer using the writer's forward pointer.
- R6: After a write, the home head is the writer. The writer's forward and backward pointers are null and it is present. Every other former sharer of the block is no longer present.
- R7: An evict (req_op 2) of a middle node sets its predecessor's forward pointer to its successor and its successor's backward pointer to its predecessor, and clears its presence.
- R8: An evict of the head makes the successor the home head with a null backward pointer. An evict of the tail sets the predecessor's forward pointer to null.
- R9: An evict of a node that is not in the chain, and a no-op (req_op 3), change nothing.
- R10: done is high for exactly one cycle at the end of every request, and req_ready is high only when idle. A request on one block leaves the chains of all other blocks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered; taken when req_ready is high |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Target memory block |
| req_ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle pulse when a request has completed |
| inv_valid | output | 1 | Invalidation message to inv_node is pending |
| inv_node | output | $clog2(NODES) | Node being invalidated |
| inv_ack | input | 1 | Acknowledge from the visited node |
| pk_blk | input | $clog2(BLOCKS) | Peek block select |
| pk_node | input | $clog2(NODES) | Peek node select |
| pk_head | output | $clog2(NODES)+1 | Home head pointer of pk_blk |
| pk_fwd | output | $clog2(NODES)+1 | Forward pointer of pk_node for pk_blk |
| pk_bwd | output | $clog2(NODES)+1 | Backward pointer of pk_node for pk_blk |
| pk_present | output | 1 | pk_node holds a copy of pk_blk |

## Verification
The acknowledge from the current sharer and the advance of the walk fall on the same clock edge. On that edge the sharer's tag is cleared while its forward pointer is read to pick the next target. The bench provokes this by acknowledging in the very first cycle an invalidation is raised, over a four-node chain and with a writer that is not a sharer. It judges the outcome by the full order of invalidations and the final chain. A second walk acknowledges after a delay, with the writer sitting in the middle of the chain, so that the step past the writer happens between two invalidations.

// File: rtl/sharer_chain_pkg.sv
package sharer_chain_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LINK,
        S_UNLINK,
        S_SCAN_START,
        S_SCAN,
        S_INVAL,
        S_CLAIM,
        S_DONE
    } state_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_LINK,
        C_UNLINK,
        C_DROP,
        C_CLAIM
    } cmd_e;

endpackage

// File: rtl/sharer_chain_store.sv
module sharer_chain_store
    import sharer_chain_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 4,
    localparam int NW = $clog2(NODES),
    localparam int PW = NW + 1,
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_op,
    input  logic [NW-1:0] cmd_node,
    input  logic [BW-1:0] cmd_blk,
    input  logic [NW-1:0] rd_node,
    input  logic [BW-1:0] rd_blk,
    output logic [PW-1:0] rd_head,
    output logic [PW-1:0] rd_fwd,
    output logic          rd_pres,
    input  logic [NW-1:0] pk_node,
    input  logic [BW-1:0] pk_blk,
    output logic [PW-1:0] pk_head,
    output logic [PW-1:0] pk_fwd,
    output logic [PW-1:0] pk_bwd,
    output logic          pk_pres
);

    // Null marker: top pointer bit set, node bits clear (equals NODES).
    localparam logic [PW-1:0] NIL = {1'b1, {NW{1'b0}}};

    logic [PW-1:0] head_q [BLOCKS];
    logic [PW-1:0] fwd_q  [BLOCKS][NODES];
    logic [PW-1:0] bwd_q  [BLOCKS][NODES];
    logic          pres_q [BLOCKS][NODES];

    // Neighbourhood of the node named by the current command.
    logic [PW-1:0] c_head;
    logic [PW-1:0] c_prev;
    logic [PW-1:0] c_next;
    logic [PW-1:0] c_self;

    always_comb begin
        c_head = head_q[cmd_blk];
        c_prev = bwd_q[cmd_blk][cmd_node];
        c_next = fwd_q[cmd_blk][cmd_node];
        c_self = {1'b0, cmd_node};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                head_q[b] <= NIL;
                for (int n = 0; n < NODES; n++) begin
                    fwd_q[b][n]  <= NIL;
                    bwd_q[b][n]  <= NIL;
                    pres_q[b][n] <= 1'b0;
                end
            end
        end else begin
            unique case (cmd_op)
                C_LINK: begin
                    fwd_q[cmd_blk][cmd_node]  <= c_head;
                    bwd_q[cmd_blk][cmd_node]  <= NIL;
                    pres_q[cmd_blk][cmd_node] <= 1'b1;
                    head_q[cmd_blk]           <= c_self;
                    if (!c_head[NW])
                        bwd_q[cmd_blk][c_head[NW-1:0]] <= c_self;
                end
                C_UNLINK: begin
                    if (c_prev[NW])
                        head_q[cmd_blk] <= c_next;
                    else
                        fwd_q[cmd_blk][c_prev[NW-1:0]] <= c_next;
                    if (!c_next[NW])
                        bwd_q[cmd_blk][c_next[NW-1:0]] <= c_prev;
                    fwd_q[cmd_blk][cmd_node]  <= NIL;
                    bwd_q[cmd_blk][cmd_node]  <= NIL;
                    pres_q[cmd_blk][cmd_node] <= 1'b0;
                end
                C_DROP: begin
                    fwd_q[cmd_blk][cmd_node]  <= NIL;
                    bwd_q[cmd_blk][cmd_node]  <= NIL;
                    pres_q[cmd_blk][cmd_node] <= 1'b0;
                end
                C_CLAIM: begin
                    head_q[cmd_blk]           <= c_self;
                    fwd_q[cmd_blk][cmd_node]  <= NIL;
                    bwd_q[cmd_blk][cmd_node]  <= NIL;
                    pres_q[cmd_blk][cmd_node] <= 1'b1;
                end
                C_NONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Controller read port and peek port.
    always_comb begin
        rd_head = head_q[rd_blk];
        rd_fwd  = fwd_q[rd_blk][rd_node];
        rd_pres = pres_q[rd_blk][rd_node];
        pk_head = head_q[pk_blk];
        pk_fwd  = fwd_q[pk_blk][pk_node];
        pk_bwd  = bwd_q[pk_blk][pk_node];
        pk_pres = pres_q[pk_blk][pk_node];
    end

    // R2: a present node with a null backward pointer must be the block's head.
    for (genvar gb = 0; gb < BLOCKS; gb++) begin : g_blk_chk
        for (genvar gn = 0; gn < NODES; gn++) begin : g_node_chk
            always_comb begin
                if (rst_n && pres_q[gb][gn] && bwd_q[gb][gn][NW]) begin
                    assert_head_bwd_null_R2: assert (head_q[gb] == PW'(gn))
                        else $error("present node with null back pointer is not head");
                end
            end
        end
    end

endmodule

// File: rtl/sharer_chain_fsm.sv
module sharer_chain_fsm
    import sharer_chain_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 4,
    localparam int NW = $clog2(NODES),
    localparam int PW = NW + 1,
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  op_e           req_op,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    output logic          req_ready,
    output logic          done,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    input  logic          inv_ack,
    output cmd_e          cmd_op,
    output logic [NW-1:0] cmd_node,
    output logic [BW-1:0] cmd_blk,
    output logic [NW-1:0] rd_node,
    output logic [BW-1:0] rd_blk,
    input  logic [PW-1:0] rd_head,
    input  logic [PW-1:0] rd_fwd,
    input  logic          rd_pres
);

    localparam logic [PW-1:0] NIL = {1'b1, {NW{1'b0}}};

    state_e        st_q, st_d;
    logic [NW-1:0] node_q;
    logic [BW-1:0] blk_q;
    logic [PW-1:0] cur_q;
    logic          walking;
    logic          cur_nil;
    logic          cur_is_writer;

    always_comb begin
        walking       = (st_q == S_SCAN_START) || (st_q == S_SCAN) || (st_q == S_INVAL);
        cur_nil       = cur_q[NW];
        cur_is_writer = !cur_q[NW] && (cur_q[NW-1:0] == node_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (req_op)
                        OP_READ:  st_d = S_LINK;
                        OP_WRITE: st_d = S_SCAN_START;
                        OP_EVICT: st_d = S_UNLINK;
                        OP_NOP:   st_d = S_DONE;
                        default:  st_d = S_DONE;
                    endcase
                end
            end
            S_LINK:       st_d = S_DONE;
            S_UNLINK:     st_d = S_DONE;
            S_SCAN_START: st_d = S_SCAN;
            S_SCAN: begin
                if (cur_nil)            st_d = S_CLAIM;
                else if (!cur_is_writer) st_d = S_INVAL;
            end
            S_INVAL: begin
                if (inv_ack) st_d = S_SCAN;
            end
            S_CLAIM:      st_d = S_DONE;
            S_DONE:       st_d = S_IDLE;
            default:      st_d = S_IDLE;
        endcase
    end

    // Request latch and walk cursor.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q <= '0;
            blk_q  <= '0;
            cur_q  <= NIL;
        end else begin
            if (st_q == S_IDLE && req_valid) begin
                node_q <= req_node;
                blk_q  <= req_blk;
            end
            if (st_q == S_SCAN_START)
                cur_q <= rd_head;
            else if (st_q == S_SCAN && !cur_nil && cur_is_writer)
                cur_q <= rd_fwd;
            else if (st_q == S_INVAL && inv_ack)
                cur_q <= rd_fwd;
        end
    end

    // Outputs and store commands.
    always_comb begin
        req_ready = (st_q == S_IDLE);
        done      = (st_q == S_DONE);
        inv_valid = (st_q == S_INVAL);
        inv_node  = cur_q[NW-1:0];
        rd_blk    = blk_q;
        rd_node   = walking ? cur_q[NW-1:0] : node_q;
        cmd_blk   = blk_q;
        cmd_node  = node_q;
        cmd_op    = C_NONE;
        unique case (st_q)
            S_LINK:   if (!rd_pres) cmd_op = C_LINK;
            S_UNLINK: if (rd_pres)  cmd_op = C_UNLINK;
            S_INVAL: begin
                cmd_node = cur_q[NW-1:0];
                if (inv_ack) cmd_op = C_DROP;
            end
            S_CLAIM:  cmd_op = C_CLAIM;
            default:  cmd_op = C_NONE;
        endcase
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!inv_valid && !done));

    assert_inv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ack) |=> (inv_valid && $stable(inv_node)));

    assert_inv_not_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_node != node_q));

endmodule

// File: rtl/sharer_chain_mgr.sv
module sharer_chain_mgr
    import sharer_chain_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 4,
    localparam int NW = $clog2(NODES),
    localparam int PW = NW + 1,
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    output logic          req_ready,
    output logic          done,
    output logic          inv_valid,
    output logic [NW-1:0] inv_node,
    input  logic          inv_ack,
    input  logic [BW-1:0] pk_blk,
    input  logic [NW-1:0] pk_node,
    output logic [PW-1:0] pk_head,
    output logic [PW-1:0] pk_fwd,
    output logic [PW-1:0] pk_bwd,
    output logic          pk_present
);

    cmd_e          cmd_op;
    logic [NW-1:0] cmd_node;
    logic [BW-1:0] cmd_blk;
    logic [NW-1:0] rd_node;
    logic [BW-1:0] rd_blk;
    logic [PW-1:0] rd_head;
    logic [PW-1:0] rd_fwd;
    logic          rd_pres;

    sharer_chain_fsm #(.NODES(NODES), .BLOCKS(BLOCKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_node  (req_node),
        .req_blk   (req_blk),
        .req_ready (req_ready),
        .done      (done),
        .inv_valid (inv_valid),
        .inv_node  (inv_node),
        .inv_ack   (inv_ack),
        .cmd_op    (cmd_op),
        .cmd_node  (cmd_node),
        .cmd_blk   (cmd_blk),
        .rd_node   (rd_node),
        .rd_blk    (rd_blk),
        .rd_head   (rd_head),
        .rd_fwd    (rd_fwd),
        .rd_pres   (rd_pres)
    );

    sharer_chain_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_op   (cmd_op),
        .cmd_node (cmd_node),
        .cmd_blk  (cmd_blk),
        .rd_node  (rd_node),
        .rd_blk   (rd_blk),
        .rd_head  (rd_head),
        .rd_fwd   (rd_fwd),
        .rd_pres  (rd_pres),
        .pk_node  (pk_node),
        .pk_blk   (pk_blk),
        .pk_head  (pk_head),
        .pk_fwd   (pk_fwd),
        .pk_bwd   (pk_bwd),
        .pk_pres  (pk_present)
    );

endmodule

// File: tb/sharer_chain_mgr_bench.sv
module sharer_chain_mgr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 8;
    localparam int BLOCKS = 4;
    localparam int NIL    = NODES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [2:0] req_node = '0;
    logic [1:0] req_blk = '0;
    logic       req_ready, done, inv_valid, inv_ack = 1'b0;
    logic [2:0] inv_node;
    logic [1:0] pk_blk = '0;
    logic [2:0] pk_node = '0;
    logic [3:0] pk_head, pk_fwd, pk_bwd;
    logic       pk_present;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int inv_log [16];
    int n_inv = 0;
    int r4_bad = 0;

    sharer_chain_mgr #(.NODES(NODES), .BLOCKS(BLOCKS)) u_sharer_chain_mgr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_node(req_node), .req_blk(req_blk), .req_ready(req_ready), .done(done),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_ack(inv_ack),
        .pk_blk(pk_blk), .pk_node(pk_node), .pk_head(pk_head), .pk_fwd(pk_fwd),
        .pk_bwd(pk_bwd), .pk_present(pk_present)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_head(string tag, int b, int exp);
        pk_blk = 2'(b);
        #1;
        chk({tag, " head"}, int'(pk_head), exp);
    endtask

    task automatic chk_node(string tag, int b, int n, int fwd, int bwd, int pres);
        pk_blk  = 2'(b);
        pk_node = 3'(n);
        #1;
        chk({tag, " fwd"}, int'(pk_fwd), fwd);
        chk({tag, " bwd"}, int'(pk_bwd), bwd);
        chk({tag, " present"}, int'(pk_present), pres);
    endtask

    // Issue one request, answer invalidations after ack_dly extra cycles,
    // and check the done pulse (R10) and invalidation handshake (R4).
    task automatic run_op(int op, int node, int blk, int ack_dly);
        int  hold = 0;
        int  last = -1;
        bit  prev_v = 0;
        bit  prev_a = 0;
        bit  seen = 0;
        @(negedge clk);
        chk("R10 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_node  = 3'(node);
        req_blk   = 2'(blk);
        n_inv     = 0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                seen = 1;
                break;
            end
            if (req_ready) r4_bad++;
            if (inv_valid) begin
                if (!prev_v) begin
                    inv_log[n_inv] = int'(inv_node);
                    n_inv++;
                    hold = 0;
                    last = int'(inv_node);
                end else begin
                    if (int'(inv_node) != last) r4_bad++;
                    hold++;
                end
                inv_ack = (hold >= ack_dly);
            end else begin
                if (prev_v && !prev_a) r4_bad++;
                inv_ack = 1'b0;
            end
            prev_v = inv_valid;
            prev_a = inv_ack;
            @(negedge clk);
        end
        inv_ack = 1'b0;
        chk("R10 done seen", int'(seen), 1);
        @(negedge clk);
        chk("R10 done one cycle", int'(done), 0);
        chk("R10 ready after done", int'(req_ready), 1);
    endtask

    task automatic t_reset();
        for (int b = 0; b < BLOCKS; b++) chk_head("R1 reset", b, NIL);
        chk_node("R1 reset node", 0, 3, NIL, NIL, 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 done", int'(done), 0);
        chk("R1 inv_valid", int'(inv_valid), 0);
    endtask

    task automatic t_reads();
        run_op(0, 3, 0, 0);
        run_op(0, 5, 0, 0);
        run_op(0, 1, 0, 0);
        chk_head("R2 insert", 0, 1);
        chk_node("R2 new head", 0, 1, 5, NIL, 1);
        chk_node("R2 middle", 0, 5, 3, 1, 1);
        chk_node("R2 tail", 0, 3, NIL, 5, 1);
        chk_head("R10 other block", 1, NIL);
        chk("R2 no invalidations", n_inv, 0);
    endtask

    task automatic t_dup_read();
        run_op(0, 5, 0, 0);
        chk_head("R3 dup read", 0, 1);
        chk_node("R3 dup node", 0, 5, 3, 1, 1);
        chk_node("R3 dup head node", 0, 1, 5, NIL, 1);
    endtask

    task automatic t_evict_mid();
        run_op(2, 5, 0, 0);
        chk_node("R7 pred", 0, 1, 3, NIL, 1);
        chk_node("R7 succ", 0, 3, NIL, 1, 1);
        chk_node("R7 removed", 0, 5, NIL, NIL, 0);
        chk_head("R7 head kept", 0, 1);
    endtask

    task automatic t_ignored();
        run_op(2, 6, 0, 0);
        chk_head("R9 evict absent", 0, 1);
        chk_node("R9 evict absent node", 0, 1, 3, NIL, 1);
        run_op(3, 1, 0, 0);
        chk_head("R9 nop", 0, 1);
        chk_node("R9 nop node", 0, 3, NIL, 1, 1);
    endtask

    task automatic t_evict_ends();
        run_op(0, 5, 0, 0);
        run_op(2, 5, 0, 0);
        chk_head("R8 evict head", 0, 1);
        chk_node("R8 new head", 0, 1, 3, NIL, 1);
        run_op(2, 3, 0, 0);
        chk_node("R8 evict tail", 0, 1, NIL, NIL, 1);
        chk_node("R8 tail gone", 0, 3, NIL, NIL, 0);
        run_op(0, 3, 0, 0);
        run_op(0, 5, 0, 0);
    endtask

    task automatic t_write_mid_writer();
        r4_bad = 0;
        run_op(1, 3, 0, 2);
        chk("R4 inv count", n_inv, 2);
        chk("R4 first inv", inv_log[0], 5);
        chk("R5 writer skipped", inv_log[1], 1);
        chk("R4 handshake", r4_bad, 0);
        chk_head("R6 head", 0, 3);
        chk_node("R6 writer", 0, 3, NIL, NIL, 1);
        chk_node("R6 dropped 5", 0, 5, NIL, NIL, 0);
        chk_node("R6 dropped 1", 0, 1, NIL, NIL, 0);
    endtask

    task automatic t_write_fast_ack();
        run_op(0, 0, 2, 0);
        run_op(0, 7, 2, 0);
        run_op(0, 2, 2, 0);
        run_op(0, 4, 2, 0);
        r4_bad = 0;
        run_op(1, 6, 2, 0);
        chk("R4 fast count", n_inv, 4);
        chk("R4 fast order 0", inv_log[0], 4);
        chk("R4 fast order 1", inv_log[1], 2);
        chk("R4 fast order 2", inv_log[2], 7);
        chk("R4 fast order 3", inv_log[3], 0);
        chk("R4 fast handshake", r4_bad, 0);
        chk_head("R6 fast head", 2, 6);
        chk_node("R6 fast writer", 2, 6, NIL, NIL, 1);
        chk_node("R6 fast dropped", 2, 7, NIL, NIL, 0);
        chk_head("R10 block0 untouched", 0, 3);
    endtask

    task automatic t_write_empty();
        run_op(1, 2, 3, 0);
        chk("R5 empty no inv", n_inv, 0);
        chk_head("R6 empty head", 3, 2);
        chk_node("R6 empty writer", 3, 2, NIL, NIL, 1);
        chk_head("R10 block1 still empty", 1, NIL);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_dup_read();
        t_evict_mid();
        t_ignored();
        t_evict_ends();
        t_write_mid_writer();
        t_write_fast_ack();
        t_write_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule